// File: doc/BRIEF.md
# Receive-and-Acknowledge-Only Transmit Gate

This block sits between a CAN protocol engine and the transmit pin and implements a restricted operating mode in which the node listens to the bus and acknowledges frames but never drives any other dominant bit. The block owns the mode bit. The host can set it only while both the init bit and the configuration-enable bit are high, and can clear it at any time.

While the mode is active, the gated transmit output is held recessive except in acknowledge slots that the engine requests. Requests from the engine to increment the transmit or receive error counters are blocked. When the engine reports an error or overload condition, the block enters a resynchronization state. In that state it drives nothing, not even acknowledge bits, until the bus has been idle for a configurable number of consecutive recessive samples (11 by default).

Top module: `rxg_gate_top`

## Requirements
- R1: After a synchronous reset, the mode bit and resync_o are 0, tx_o is 1 (recessive), and both increment enables are 0.
- R2: A host write with cfg_wr_mode=1 sets the mode bit on the next clock only when cfg_init=1 and cfg_cce=1. Otherwise the write is ignored and mode_o keeps its value.
- R3: A host write with cfg_wr_mode=0 clears the mode bit on the next clock, whatever the values of cfg_init and cfg_cce.
- R4: While the mode bit is 0, tx_o equals pe_tx one clock later, and tec_inc_o and rec_inc_o equal pe_tec_inc and pe_rec_inc one clock later.
- R5: While the mode bit is 1 and resync_o is 0, tx_o one clock later is pe_tx if pe_ack_slot=1 and 1 (recessive) otherwise.
- R6: While the mode bit is 1, tec_inc_o and rec_inc_o are 0 one clock later.
- R7: With the mode bit at 1, pe_err=1 sets resync_o on the next clock. While resync_o is 1, tx_o stays recessive even in acknowledge slots. resync_o falls one clock after the IDLE_BITS-th consecutive recessive sample (rx_sample=1, rx_bit=1).
- R8: A sample with rx_bit=0 restarts the count of consecutive recessive samples.
- R9: Clearing the mode bit ends the resynchronization state on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Host write strobe for the mode bit |
| cfg_wr_mode | input | 1 | Value the host writes to the mode bit |
| cfg_init | input | 1 | Current init bit of the host control register |
| cfg_cce | input | 1 | Current configuration-enable bit |
| pe_tx | input | 1 | Engine transmit bit (1 = recessive) |
| pe_ack_slot | input | 1 | Engine requests driving an acknowledge slot |
| pe_err | input | 1 | Engine reports an error or overload condition |
| pe_tec_inc | input | 1 | Engine request to increment the transmit error counter |
| pe_rec_inc | input | 1 | Engine request to increment the receive error counter |
| rx_bit | input | 1 | Sampled bus level (1 = recessive) |
| rx_sample | input | 1 | Strobe marking a valid rx_bit sample |
| mode_o | output | 1 | Current mode bit |
| tx_o | output | 1 | Gated transmit bit |
| tec_inc_o | output | 1 | Gated transmit error counter increment |
| rec_inc_o | output | 1 | Gated receive error counter increment |
| resync_o | output | 1 | Waiting for bus idle after an error |

## Verification
The assertions assume that cfg_init and cfg_cce are stable register values, and that rx_sample pulses for one clock per bit. They also assume that pe_err is a single-clock pulse, not a level held across a whole idle period. The stimulus changes inputs only at falling edges. It raises pe_err for exactly one clock, and it drives rx_sample once per clock during idle runs, so each strobe counts as one bit. Writes that violate the set permission are applied deliberately, and their effect is observed only through mode_o.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam logic RECESSIVE = 1'b1;
  localparam logic DOMINANT  = 1'b0;

  typedef struct packed {
    logic tec;
    logic rec;
  } inc_t;
endpackage

// File: rtl/rxg_mode_reg.sv
module rxg_mode_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_val,
  input  logic init_bit,
  input  logic cce_bit,
  output logic mode_q
);
  logic set_ok;
  assign set_ok = init_bit & cce_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
    end else if (wr_en) begin
      if (!wr_val)
        mode_q <= 1'b0;
      else if (set_ok)
        mode_q <= 1'b1;
    end
  end

  assert_set_guard_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q) |-> $past(wr_en && wr_val && init_bit && cce_bit));
  assert_clear_any_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_val) |=> !mode_q);
endmodule

// File: rtl/rxg_idle_det.sv
module rxg_idle_det #(
  parameter int IDLE_BITS = 11,
  localparam int CNT_W = $clog2(IDLE_BITS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic sample,
  input  logic rx_bit,
  output logic idle
);
  import rxg_pkg::*;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_BITS);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (sample) begin
      if (rx_bit != RECESSIVE)
        cnt_q <= '0;
      else if (cnt_q != LIMIT)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idle = (cnt_q == LIMIT);

  assert_cnt_cap_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
  assert_dom_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (sample && rx_bit == DOMINANT) |=> !idle);
endmodule

// File: rtl/rxg_gate_top.sv
module rxg_gate_top #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr_en,
  input  logic cfg_wr_mode,
  input  logic cfg_init,
  input  logic cfg_cce,
  input  logic pe_tx,
  input  logic pe_ack_slot,
  input  logic pe_err,
  input  logic pe_tec_inc,
  input  logic pe_rec_inc,
  input  logic rx_bit,
  input  logic rx_sample,
  output logic mode_o,
  output logic tx_o,
  output logic tec_inc_o,
  output logic rec_inc_o,
  output logic resync_o
);
  import rxg_pkg::*;

  logic mode_q, resync_q, idle, enter_resync;
  inc_t inc_q;

  rxg_mode_reg u_mode (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_val(cfg_wr_mode),
    .init_bit(cfg_init), .cce_bit(cfg_cce), .mode_q(mode_q)
  );

  assign enter_resync = mode_q & pe_err;

  rxg_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst(rst), .restart(enter_resync), .sample(rx_sample),
    .rx_bit(rx_bit), .idle(idle)
  );

  always_ff @(posedge clk) begin
    if (rst)
      resync_q <= 1'b0;
    else if (enter_resync)
      resync_q <= 1'b1;
    else if (!mode_q || idle)
      resync_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_o  <= RECESSIVE;
      inc_q <= '0;
    end else if (!mode_q) begin
      tx_o  <= pe_tx;
      inc_q <= '{tec: pe_tec_inc, rec: pe_rec_inc};
    end else begin
      tx_o  <= (pe_ack_slot && !resync_q) ? pe_tx : RECESSIVE;
      inc_q <= '0;
    end
  end

  assign mode_o    = mode_q;
  assign resync_o  = resync_q;
  assign tec_inc_o = inc_q.tec;
  assign rec_inc_o = inc_q.rec;

  assert_tx_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !pe_ack_slot) |=> tx_o);
  assert_no_inc_R6: assert property (@(posedge clk) disable iff (rst)
    mode_q |=> (!tec_inc_o && !rec_inc_o));
  assert_quiet_resync_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q && resync_q) |=> tx_o);
  assert_exit_on_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !pe_err) |=> !resync_q);
endmodule

// File: tb/rxg_gate_top_tb_top.sv
module rxg_gate_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr_en = 0, cfg_wr_mode = 0, cfg_init = 0, cfg_cce = 0;
  logic pe_tx = 1, pe_ack_slot = 0, pe_err = 0, pe_tec_inc = 0, pe_rec_inc = 0;
  logic rx_bit = 1, rx_sample = 0;
  logic mode_o, tx_o, tec_inc_o, rec_inc_o, resync_o;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    int    sel;
    logic  exp;
    string tag;
  } item_t;
  item_t sb_q[$];
  event chk_ev;

  always #10 clk = ~clk;

  rxg_gate_top #(.IDLE_BITS(11)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_mode(cfg_wr_mode),
    .cfg_init(cfg_init), .cfg_cce(cfg_cce), .pe_tx(pe_tx),
    .pe_ack_slot(pe_ack_slot), .pe_err(pe_err), .pe_tec_inc(pe_tec_inc),
    .pe_rec_inc(pe_rec_inc), .rx_bit(rx_bit), .rx_sample(rx_sample),
    .mode_o(mode_o), .tx_o(tx_o), .tec_inc_o(tec_inc_o),
    .rec_inc_o(rec_inc_o), .resync_o(resync_o)
  );

  function automatic logic pick(int sel);
    case (sel)
      0: return mode_o;
      1: return tx_o;
      2: return tec_inc_o;
      3: return rec_inc_o;
      default: return resync_o;
    endcase
  endfunction

  always begin
    @(chk_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      logic act;
      it = sb_q.pop_front();
      act = pick(it.sel);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%b expected=%b", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_v(int sel, logic exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_write(logic val, logic ini, logic cce);
    cfg_wr_en = 1; cfg_wr_mode = val; cfg_init = ini; cfg_cce = cce;
    tick();
    cfg_wr_en = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 0;
    // R1 reset state
    expect_v(0, 0, "R1 mode"); expect_v(1, 1, "R1 tx");
    expect_v(2, 0, "R1 tec");  expect_v(3, 0, "R1 rec");
    expect_v(4, 0, "R1 resync");

    // R4 pass-through with mode off
    pe_tx = 0; tick(); expect_v(1, 0, "R4 tx dominant passes");
    pe_tx = 1; pe_tec_inc = 1; pe_rec_inc = 1; tick();
    expect_v(2, 1, "R4 tec passes"); expect_v(3, 1, "R4 rec passes");
    pe_tec_inc = 0; pe_rec_inc = 0;

    // R2 set permission
    host_write(1, 1, 0); expect_v(0, 0, "R2 cce low ignored");
    host_write(1, 0, 1); expect_v(0, 0, "R2 init low ignored");
    host_write(1, 1, 1); expect_v(0, 1, "R2 set allowed");

    // R5 gating
    pe_tx = 0; tick(); expect_v(1, 1, "R5 frame bit blocked");
    pe_ack_slot = 1; tick(); expect_v(1, 0, "R5 ack passes");
    pe_ack_slot = 0; pe_tx = 1;

    // R6 counters blocked
    pe_tec_inc = 1; pe_rec_inc = 1; tick();
    expect_v(2, 0, "R6 tec blocked"); expect_v(3, 0, "R6 rec blocked");
    pe_tec_inc = 0; pe_rec_inc = 0;

    // R7 error enters resync, ack suppressed
    pe_err = 1; tick(); pe_err = 0;
    expect_v(4, 1, "R7 resync entered");
    pe_ack_slot = 1; pe_tx = 0; tick();
    expect_v(1, 1, "R7 ack blocked in resync");
    pe_ack_slot = 0; pe_tx = 1;

    // R8 dominant sample restarts count
    rx_sample = 1; rx_bit = 1;
    for (int i = 0; i < 5; i++) tick();
    rx_bit = 0; tick(); rx_bit = 1;
    for (int i = 0; i < 10; i++) tick();
    expect_v(4, 1, "R8 ten after restart still waiting");
    tick();
    rx_sample = 0;
    expect_v(4, 1, "R7 eleventh sample registered");
    tick();
    expect_v(4, 0, "R7 idle ends resync");

    // R9 / R3 clear ends resync
    pe_err = 1; tick(); pe_err = 0;
    expect_v(4, 1, "R9 resync again");
    host_write(0, 0, 0); expect_v(0, 0, "R3 clear with init low");
    tick(); expect_v(4, 0, "R9 resync dropped");
    pe_tx = 0; tick(); expect_v(1, 0, "R4 tx follows after clear");
    pe_tx = 1; tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule